// File: doc/BRIEF.md
# Oscillator Failure Reset Detector

This block watches the crystal-derived clock and asks for a system reset when that clock has become too slow or has stopped. All of its logic runs on a ring-oscillator clock that keeps going when the crystal dies. The crystal signal is treated as plain data. It passes through a synchronizer, and its rising edges are counted over fixed windows of ring-oscillator cycles. A window that ends with fewer edges than the number a 20 kHz crystal would give marks the crystal as failed. The reset request then stays high, and the ring oscillator keeps clocking the detector, until a later full window sees enough edges again.

Detection runs only while a software enable flag is 1. Software sets the flag with a one-cycle pulse. Only a software clear or a power-fail reset can return it to 0. The other reset sources enter through a separate synchronous input. That input restarts the measurement but leaves the flag alone. The result of the first window after detection starts is thrown away, so a measurement that began part-way through a crystal period cannot trip the reset.

Top module: `osc_fail_detector`

## Requirements
- R1: While enabled, a window of `WIN_LEN` ring cycles that counts fewer crystal rising edges than `floor(TRIP_HZ*WIN_LEN/RING_HZ)` raises `osc_rst_req` in the cycle after that window's last cycle.
- R2: While `det_en` is 0, `osc_rst_req` stays 0 whatever the crystal does.
- R3: Once raised, `osc_rst_req` stays 1 until a window that counts at least the threshold number of edges ends. It falls at the end of that window.
- R4: The verdict of the first window after `det_en` rises, or after a `sys_rst` pulse, is discarded. A stopped crystal therefore raises the request only at the end of the second window.
- R5: A pulse on `en_set` sets `det_en` to 1. A pulse on `en_clr` clears it to 0. When both are 1 in the same cycle, the clear wins.
- R6: `sys_rst` leaves `det_en` unchanged. It drops `osc_rst_req` on the next cycle and restarts the window count.
- R7: `pf_rst` clears `det_en` and `osc_rst_req` at once, without waiting for a clock edge.
- R8: Clearing the enable drops `osc_rst_req` one cycle after `det_en` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ring_clk | input | 1 | Always-running ring-oscillator reference clock |
| pf_rst | input | 1 | Power-fail reset, asynchronous, active high |
| sys_rst | input | 1 | Other reset sources, synchronous to ring_clk, active high |
| xtal_clk | input | 1 | Crystal-derived clock under observation |
| en_set | input | 1 | Software write that sets the enable |
| en_clr | input | 1 | Software write that clears the enable |
| osc_rst_req | output | 1 | Reset request, held while the crystal is judged failed |
| det_en | output | 1 | Current state of the detection enable |

## Verification
The hardest state to reach is one where the request is already held and the crystal then comes back. From there the bench has to tell "still held mid-window" apart from "released at the next window end". The same difficulty applies to the discarded first window after a restart. The stimulus starts each window in a known cycle by pulsing `en_set` or `sys_rst` at a chosen edge. It stops the crystal, so the first window ends in a known cycle. Samples are then taken just after the first window end and just after the second one. A clean crystal is restored part-way through a window, and the bench confirms that the request holds until a full window has passed.

// File: rtl/ofd_pkg.sv
package ofd_pkg;

  // Fewest edges a window must contain at the trip frequency.
  function automatic int unsigned min_edges(input longint unsigned ring_hz,
                                            input longint unsigned trip_hz,
                                            input longint unsigned win_len);
    longint unsigned prod;
    prod = (trip_hz * win_len) / ring_hz;
    return 32'(prod);
  endfunction

  // Verdict for one window: 1 means the crystal is judged failed.
  function automatic logic too_slow(input int unsigned seen,
                                    input int unsigned floor_v);
    return seen < floor_v;
  endfunction

endpackage

// File: rtl/xtal_edge_sync.sv
module xtal_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pf_rst,
  input  logic xtal_in,
  output logic rise_pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or posedge pf_rst) begin
    if (pf_rst) chain <= '0;
    else        chain <= {chain[STAGES-1:0], xtal_in};
  end

  assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/ofd_enable_reg.sv
module ofd_enable_reg (
  input  logic clk,
  input  logic pf_rst,
  input  logic en_set,
  input  logic en_clr,
  output logic en_q
);
  // Only the power-fail reset and a software clear can drop the flag.
  always_ff @(posedge clk or posedge pf_rst) begin
    if (pf_rst)      en_q <= 1'b0;
    else if (en_clr) en_q <= 1'b0;
    else if (en_set) en_q <= 1'b1;
  end
endmodule

// File: rtl/ofd_window_timer.sv
module ofd_window_timer #(
  parameter int WIN_LEN = 1024
) (
  input  logic clk,
  input  logic pf_rst,
  input  logic sys_rst,
  input  logic active,
  output logic win_end
);
  localparam int TW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_LEN - 1);

  logic [TW-1:0] tick;

  always_ff @(posedge clk or posedge pf_rst) begin
    if (pf_rst)                 tick <= '0;
    else if (sys_rst || !active) tick <= '0;
    else if (tick == LAST)       tick <= '0;
    else                         tick <= tick + 1'b1;
  end

  assign win_end = active && (tick == LAST);
endmodule

// File: rtl/ofd_edge_tally.sv
module ofd_edge_tally #(
  parameter int WIN_LEN   = 1024,
  parameter int MIN_EDGES = 2
) (
  input  logic clk,
  input  logic pf_rst,
  input  logic sys_rst,
  input  logic active,
  input  logic rise_pulse,
  input  logic win_end,
  output logic fail_q,
  output logic discard_pend
);
  import ofd_pkg::*;

  localparam int CW = $clog2(WIN_LEN + 1);

  logic [CW-1:0] seen;
  logic [CW-1:0] total;
  logic          verdict;

  assign total   = seen + CW'(rise_pulse);
  assign verdict = too_slow(32'(total), MIN_EDGES);

  always_ff @(posedge clk or posedge pf_rst) begin
    if (pf_rst) begin
      seen         <= '0;
      discard_pend <= 1'b1;
      fail_q       <= 1'b0;
    end else if (sys_rst || !active) begin
      seen         <= '0;
      discard_pend <= 1'b1;
      fail_q       <= 1'b0;
    end else if (win_end) begin
      seen         <= '0;
      discard_pend <= 1'b0;
      if (!discard_pend) fail_q <= verdict;
    end else begin
      seen <= total;
    end
  end
endmodule

// File: rtl/osc_fail_detector.sv
module osc_fail_detector #(
  parameter longint unsigned RING_HZ  = 10_000_000,
  parameter longint unsigned TRIP_HZ  = 20_000,
  parameter int              WIN_LEN  = 1024,
  parameter int              SYNC_STG = 2
) (
  input  logic ring_clk,
  input  logic pf_rst,
  input  logic sys_rst,
  input  logic xtal_clk,
  input  logic en_set,
  input  logic en_clr,
  output logic osc_rst_req,
  output logic det_en
);
  import ofd_pkg::*;

  localparam int MIN_EDGES = int'(min_edges(RING_HZ, TRIP_HZ, 64'(WIN_LEN)));

  logic rise_pulse;
  logic win_end;
  logic discard_pend;

  xtal_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(ring_clk), .pf_rst(pf_rst), .xtal_in(xtal_clk), .rise_pulse(rise_pulse)
  );

  ofd_enable_reg u_en (
    .clk(ring_clk), .pf_rst(pf_rst), .en_set(en_set), .en_clr(en_clr), .en_q(det_en)
  );

  ofd_window_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk(ring_clk), .pf_rst(pf_rst), .sys_rst(sys_rst), .active(det_en),
    .win_end(win_end)
  );

  ofd_edge_tally #(.WIN_LEN(WIN_LEN), .MIN_EDGES(MIN_EDGES)) u_tally (
    .clk(ring_clk), .pf_rst(pf_rst), .sys_rst(sys_rst), .active(det_en),
    .rise_pulse(rise_pulse), .win_end(win_end), .fail_q(osc_rst_req),
    .discard_pend(discard_pend)
  );
endmodule

// File: rtl/osc_fail_detector_chk.sv
module osc_fail_detector_chk (
  input logic clk,
  input logic pf_rst,
  input logic sys_rst,
  input logic en_set,
  input logic en_clr,
  input logic det_en,
  input logic osc_rst_req,
  input logic win_end,
  input logic discard_pend
);
  assert_req_rise_at_window_R1: assert property (@(posedge clk) disable iff (pf_rst)
    $rose(osc_rst_req) |-> $past(win_end));

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (pf_rst)
    !det_en |=> !osc_rst_req);

  assert_req_fall_R3: assert property (@(posedge clk) disable iff (pf_rst)
    $fell(osc_rst_req) |-> ($past(win_end) || !$past(det_en) || $past(sys_rst)));

  assert_first_window_discarded_R4: assert property (@(posedge clk) disable iff (pf_rst)
    (win_end && discard_pend && !osc_rst_req) |=> !osc_rst_req);

  assert_en_fall_R5: assert property (@(posedge clk) disable iff (pf_rst)
    $fell(det_en) |-> $past(en_clr));

  assert_en_rise_R5: assert property (@(posedge clk) disable iff (pf_rst)
    $rose(det_en) |-> ($past(en_set) && !$past(en_clr)));

  assert_sysrst_keeps_en_R6: assert property (@(posedge clk) disable iff (pf_rst)
    (sys_rst && !en_set && !en_clr) |=> (det_en == $past(det_en)));
endmodule

bind osc_fail_detector osc_fail_detector_chk u_chk (
  .clk(ring_clk), .pf_rst(pf_rst), .sys_rst(sys_rst), .en_set(en_set),
  .en_clr(en_clr), .det_en(det_en), .osc_rst_req(osc_rst_req),
  .win_end(win_end), .discard_pend(discard_pend)
);

// File: tb/test_osc_fail_detector.sv
`timescale 1ns/1ps
module test_osc_fail_detector;
  // Bench scale: 256-cycle windows, a nominal 1 MHz ring, 20 kHz trip -> 5 edges.
  localparam int WIN = 256;
  localparam longint unsigned RHZ = 1_000_000;
  localparam longint unsigned THZ = 20_000;
  localparam int THRESH = int'((THZ * WIN) / RHZ);
  localparam int SETTLE = 3 * WIN;

  localparam int NV = 6;
  localparam int VEC_PER [NV] = '{20, 100, 40, 0, 45, 70};
  localparam bit VEC_EXP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic pf_rst = 1'b1, sys_rst = 1'b0, xtal = 1'b0, en_set = 1'b0, en_clr = 1'b0;
  logic osc_rst_req, det_en;
  int   xper = 20;
  int   n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  // Crystal model: period of xper ring cycles, 0 means stopped.
  initial forever begin
    if (xper == 0) begin xtal = 1'b0; #10; end
    else begin xtal = ~xtal; #(xper * 5); end
  end

  osc_fail_detector #(.RING_HZ(RHZ), .TRIP_HZ(THZ), .WIN_LEN(WIN), .SYNC_STG(2))
  i_osc_fail_detector (
    .ring_clk(clk), .pf_rst(pf_rst), .sys_rst(sys_rst), .xtal_clk(xtal),
    .en_set(en_set), .en_clr(en_clr), .osc_rst_req(osc_rst_req), .det_en(det_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Pulse a control for exactly one edge; returns at the negedge after it.
  task automatic pulse_set();  en_set = 1'b1;  cyc(1); en_set = 1'b0;  endtask
  task automatic pulse_clr();  en_clr = 1'b1;  cyc(1); en_clr = 1'b0;  endtask
  task automatic pulse_sys();  sys_rst = 1'b1; cyc(1); sys_rst = 1'b0; endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    chk("threshold sanity", THRESH, 5);
    cyc(5);
    pf_rst = 1'b0;
    cyc(2);
    chk("R7 reset req", osc_rst_req, 0);
    chk("R7 reset enable", det_en, 0);

    // R2: disabled, dead crystal never trips.
    xper = 0;
    cyc(SETTLE);
    chk("R2 disabled no request", osc_rst_req, 0);

    // R4: enable with dead crystal; first window verdict discarded.
    pulse_set();                       // enabling edge is P0
    chk("R5 set enables", det_en, 1);
    cyc(299);                          // P300: after first window end (P256)
    chk("R4 first window discarded", osc_rst_req, 0);
    cyc(230);                          // P530: after second window end (P512)
    chk("R1 dead crystal trips", osc_rst_req, 1);

    // R3: crystal returns mid-window, request holds until a full window passes.
    xper = 20;
    cyc(50);
    chk("R3 held mid-window", osc_rst_req, 1);
    cyc(SETTLE);
    chk("R3 released after good window", osc_rst_req, 0);

    // Main table: crystal period in ring cycles vs expected request.
    for (int i = 0; i < NV; i++) begin
      xper = VEC_PER[i];
      cyc(SETTLE);
      chk($sformatf("R1 vector %0d period %0d", i, VEC_PER[i]), osc_rst_req, VEC_EXP[i]);
    end

    // R6: other reset keeps enable, clears request, re-arms discard.
    xper = 0;
    cyc(SETTLE);
    chk("R1 tripped before sys_rst", osc_rst_req, 1);
    pulse_sys();                       // Q0
    chk("R6 enable kept", det_en, 1);
    chk("R6 request cleared", osc_rst_req, 0);
    cyc(299);
    chk("R4 discard after sys_rst", osc_rst_req, 0);
    cyc(230);
    chk("R1 trip after sys_rst", osc_rst_req, 1);

    // R8/R5: software clear.
    en_clr = 1'b1;
    cyc(1);
    en_clr = 1'b0;
    chk("R5 clear disables", det_en, 0);
    cyc(1);
    chk("R8 request drops after clear", osc_rst_req, 0);

    // R5: simultaneous set and clear -> clear wins.
    en_set = 1'b1; en_clr = 1'b1;
    cyc(1);
    en_set = 1'b0; en_clr = 1'b0;
    chk("R5 clear wins", det_en, 0);
    pulse_set();
    chk("R5 set again", det_en, 1);
    cyc(SETTLE);
    chk("R1 trip again", osc_rst_req, 1);

    // R7: power-fail reset is asynchronous.
    #2 pf_rst = 1'b1;
    #1;
    chk("R7 async enable clear", det_en, 0);
    chk("R7 async request clear", osc_rst_req, 0);
    cyc(2);
    pf_rst = 1'b0;
    cyc(SETTLE);
    chk("R2 stays off after power fail", osc_rst_req, 0);
    chk("R7 enable stays off", det_en, 0);

    summary();
    $finish;
  end
endmodule